// File: doc/BRIEF.md
# Mode-Switched Interrupt and DMA Request Router

This block steers interrupt and DMA requests raised by logic on an adapter card onto the shared request lines of an ISA-style expansion bus. A small set of configuration registers holds a two-bit operating mode and one 4-bit routing field per on-board request. Each field names one target bus line and carries an enable bit. The routing from the request inputs to the bus outputs is purely combinational, so a request reaches its bus line within the same cycle, with no clock edge in between.

In DMA mode the two on-board interrupts can each reach one of six bus interrupt lines. The single on-board DMA request goes to one of two bus DMA request lines, and the active-low acknowledge of the chosen channel returns to the card. In extended interrupt mode the two DMA request pins carry interrupt lines 6 and 7. The two acknowledge pins then act as high address bits, and the card-side DMA request and acknowledge pins carry chip selects 2 and 3, which an external address decoder supplies. Each bus output comes with an output-enable bit. A line that nothing selects is released, so other cards can drive it.

Top module: `irq_dma_router`

## Requirements
- R1: After reset the mode is DMA (00) and every routing field is disabled. All bus output enables are 0, `brd_dack_cs3_n` is 1 and `pin_drq_oe` is 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` at the rising clock edge: address 0 loads the mode (bits 1:0), address 1 loads the field for `brd_irq[0]`, address 2 loads the field for `brd_irq[1]`, and address 3 loads the DMA field. The outputs reflect the new value only after that edge.
- R3: In a routing field, bit 3 is the enable and bits 2:0 give the target line. A field with bit 3 clear drives no bus line.
- R4: In DMA mode (00), an enabled interrupt field with target 0 to 5 drives `bus_irq[target]` from its request and sets that line's enable. Targets 6 and 7 drive nothing.
- R5: In extended interrupt mode (01), interrupt targets 6 and 7 drive `bus_drq[0]` and `bus_drq[1]` with their enables. The DMA field is ignored.
- R6: When both interrupt fields select the same line, that line carries the OR of the two requests.
- R7: In DMA mode, an enabled DMA field with target 0 or 1 drives `bus_drq[target]` from `brd_drq` with its enable set, and `brd_dack_cs3_n` follows `bus_dack_n[target]`. With any other target, or with the field disabled, nothing is driven and `brd_dack_cs3_n` is 1.
- R8: In extended interrupt mode, `ext_addr_hi` equals `bus_dack_n`, `pin_drq_o` follows `cs2_n` with `pin_drq_oe` = 1, and `brd_dack_cs3_n` follows `cs3_n`. In other modes, `ext_addr_hi` is 0, `pin_drq_oe` is 0 and `pin_drq_o` is 1.
- R9: Modes 10 and 11 are reserved. In these modes all bus output enables are 0 and `brd_dack_cs3_n` is 1.
- R10: A bus output whose enable is 0 reads 0. Every routing path is combinational: a change on a request input appears at the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 4 | Configuration write data |
| brd_irq | input | 2 | On-board interrupt requests |
| brd_drq | input | 1 | On-board DMA request |
| cs2_n | input | 1 | Chip select 2 from the external decoder |
| cs3_n | input | 1 | Chip select 3 from the external decoder |
| bus_dack_n | input | 2 | Bus DMA acknowledges, or high address bits in extended mode |
| bus_irq | output | 6 | Bus interrupt lines 0 to 5 |
| bus_irq_oe | output | 6 | Output enables for `bus_irq` |
| bus_drq | output | 2 | Bus DMA requests, or interrupt lines 6 and 7 |
| bus_drq_oe | output | 2 | Output enables for `bus_drq` |
| brd_dack_cs3_n | output | 1 | Acknowledge to the card, or chip select 3 |
| pin_drq_o | output | 1 | Chip select 2 drive for the dual-use DMA request pin |
| pin_drq_oe | output | 1 | Output enable for the dual-use DMA request pin |
| ext_addr_hi | output | 2 | High address bits taken from the acknowledge pins |

## Verification
Configuration writes take effect one clock edge after they are presented. Every routed output then follows its inputs in the same cycle. The bench therefore applies each write half a period before a rising edge and checks the old routing just before that edge. It then changes the request, acknowledge and chip-select inputs with no clock involved and samples 1 ns after each change. It steps through every mode and every pair of interrupt fields, with the DMA field rotating, and for each of these settings drives all 128 input patterns.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
    localparam int BRD_IRQS  = 2;   // on-board interrupt sources
    localparam int BASE_IRQS = 6;   // bus interrupt lines owned in every mode
    localparam int DMA_CHANS = 2;   // bus DMA channels / extra interrupt lines
    localparam int SEL_W     = 4;   // routing field width: enable + index
    localparam int LINE_W    = SEL_W - 1;
    localparam int ALL_LINES = BASE_IRQS + DMA_CHANS;
    localparam int CFG_AW    = $clog2(BRD_IRQS + 2);

    typedef enum logic [1:0] {
        RM_DMA  = 2'b00,
        RM_EXT  = 2'b01,
        RM_RSV2 = 2'b10,
        RM_RSV3 = 2'b11
    } rtr_mode_e;

    typedef struct packed {
        rtr_mode_e                          mode;
        logic [BRD_IRQS-1:0][SEL_W-1:0]     irq_sel;
        logic [SEL_W-1:0]                   dma_sel;
    } rtr_cfg_t;
endpackage

// File: rtl/rtr_cfg_regs.sv
module rtr_cfg_regs
    import irq_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [SEL_W-1:0]  wdata,
    output rtr_cfg_t          cfg_q
);
    localparam int DMA_ADDR = BRD_IRQS + 1;

    rtr_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == '0)
                cfg_d.mode = rtr_mode_e'(wdata[1:0]);
            for (int k = 0; k < BRD_IRQS; k++)
                if (int'(addr) == k + 1)
                    cfg_d.irq_sel[k] = wdata;
            if (int'(addr) == DMA_ADDR)
                cfg_d.dma_sel = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0));
    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0) |=> (cfg_q.mode == $past(wdata[1:0])));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/rtr_irq_steer.sv
module rtr_irq_steer
    import irq_rtr_pkg::*;
(
    input  logic [BRD_IRQS-1:0]             req,
    input  logic [BRD_IRQS-1:0][SEL_W-1:0]  sel,
    input  logic [LINE_W:0]                 n_lines,
    output logic [ALL_LINES-1:0]            line_req,
    output logic [ALL_LINES-1:0]            line_hit
);
    for (genvar i = 0; i < ALL_LINES; i++) begin : g_line
        logic [BRD_IRQS-1:0] hit;
        always_comb begin
            for (int k = 0; k < BRD_IRQS; k++)
                hit[k] = sel[k][SEL_W-1]
                      && (int'(sel[k][LINE_W-1:0]) == i)
                      && (i < int'(n_lines));
        end
        assign line_hit[i] = |hit;
        assign line_req[i] = |(hit & req);
    end
endmodule

// File: rtl/rtr_dma_steer.sv
module rtr_dma_steer
    import irq_rtr_pkg::*;
(
    input  logic                  active,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  drq,
    input  logic [DMA_CHANS-1:0]  dack_n,
    output logic [DMA_CHANS-1:0]  chan_req,
    output logic [DMA_CHANS-1:0]  chan_hit,
    output logic                  brd_dack_n
);
    for (genvar j = 0; j < DMA_CHANS; j++) begin : g_chan
        assign chan_hit[j] = active && sel[SEL_W-1]
                          && (int'(sel[LINE_W-1:0]) == j);
        assign chan_req[j] = chan_hit[j] & drq;
    end

    always_comb begin
        brd_dack_n = 1'b1;
        for (int j = 0; j < DMA_CHANS; j++)
            if (chan_hit[j]) brd_dack_n = dack_n[j];
    end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
    import irq_rtr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [SEL_W-1:0]      cfg_wdata,
    input  logic [BRD_IRQS-1:0]   brd_irq,
    input  logic                  brd_drq,
    input  logic                  cs2_n,
    input  logic                  cs3_n,
    input  logic [DMA_CHANS-1:0]  bus_dack_n,
    output logic [BASE_IRQS-1:0]  bus_irq,
    output logic [BASE_IRQS-1:0]  bus_irq_oe,
    output logic [DMA_CHANS-1:0]  bus_drq,
    output logic [DMA_CHANS-1:0]  bus_drq_oe,
    output logic                  brd_dack_cs3_n,
    output logic                  pin_drq_o,
    output logic                  pin_drq_oe,
    output logic [DMA_CHANS-1:0]  ext_addr_hi
);
    rtr_cfg_t cfg_q;
    logic     is_dma, is_ext;
    logic [LINE_W:0]          n_lines;
    logic [ALL_LINES-1:0]     line_req, line_hit;
    logic [DMA_CHANS-1:0]     chan_req, chan_hit;
    logic                     dma_dack_n;

    rtr_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    assign is_dma = (cfg_q.mode == RM_DMA);
    assign is_ext = (cfg_q.mode == RM_EXT);

    always_comb begin
        unique case (cfg_q.mode)
            RM_DMA:  n_lines = (LINE_W+1)'(BASE_IRQS);
            RM_EXT:  n_lines = (LINE_W+1)'(ALL_LINES);
            default: n_lines = '0;
        endcase
    end

    rtr_irq_steer u_irq (
        .req      (brd_irq),
        .sel      (cfg_q.irq_sel),
        .n_lines  (n_lines),
        .line_req (line_req),
        .line_hit (line_hit)
    );

    rtr_dma_steer u_dma (
        .active     (is_dma),
        .sel        (cfg_q.dma_sel),
        .drq        (brd_drq),
        .dack_n     (bus_dack_n),
        .chan_req   (chan_req),
        .chan_hit   (chan_hit),
        .brd_dack_n (dma_dack_n)
    );

    assign bus_irq    = line_req[BASE_IRQS-1:0];
    assign bus_irq_oe = line_hit[BASE_IRQS-1:0];

    always_comb begin
        if (is_ext) begin
            bus_drq        = line_req[ALL_LINES-1:BASE_IRQS];
            bus_drq_oe     = line_hit[ALL_LINES-1:BASE_IRQS];
            brd_dack_cs3_n = cs3_n;
            pin_drq_o      = cs2_n;
            pin_drq_oe     = 1'b1;
            ext_addr_hi    = bus_dack_n;
        end else begin
            bus_drq        = chan_req;
            bus_drq_oe     = chan_hit;
            brd_dack_cs3_n = dma_dack_n;
            pin_drq_o      = 1'b1;
            pin_drq_oe     = 1'b0;
            ext_addr_hi    = '0;
        end
    end

    // R7
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_dma |-> $onehot0(bus_drq_oe));
    // R7
    dack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dma && !brd_dack_cs3_n) |-> (bus_dack_n != '1));
    // R9
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.mode[1] |-> (bus_irq_oe == '0 && bus_drq_oe == '0 && brd_dack_cs3_n));
    // R8
    ext_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> (pin_drq_oe && ext_addr_hi == bus_dack_n));
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_irq & ~bus_irq_oe) == '0) && ((bus_drq & ~bus_drq_oe) == '0));
endmodule

// File: tb/irq_dma_router_test.sv
module irq_dma_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [3:0] cfg_wdata = '0;
    logic [1:0] brd_irq = '0;
    logic       brd_drq = 1'b0;
    logic       cs2_n = 1'b1;
    logic       cs3_n = 1'b1;
    logic [1:0] bus_dack_n = 2'b11;
    logic [5:0] bus_irq, bus_irq_oe;
    logic [1:0] bus_drq, bus_drq_oe, ext_addr_hi;
    logic       brd_dack_cs3_n, pin_drq_o, pin_drq_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_dma_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .brd_irq(brd_irq), .brd_drq(brd_drq),
        .cs2_n(cs2_n), .cs3_n(cs3_n), .bus_dack_n(bus_dack_n),
        .bus_irq(bus_irq), .bus_irq_oe(bus_irq_oe), .bus_drq(bus_drq),
        .bus_drq_oe(bus_drq_oe), .brd_dack_cs3_n(brd_dack_cs3_n),
        .pin_drq_o(pin_drq_o), .pin_drq_oe(pin_drq_oe), .ext_addr_hi(ext_addr_hi)
    );

    // bench copy of configuration
    logic [1:0] m_mode;
    logic [3:0] m_s0, m_s1, m_sd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d s0=%h s1=%h sd=%h actual=%h expected=%h",
                     tag, m_mode, m_s0, m_s1, m_sd, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic compare_all();
        logic [7:0] hit, req;
        logic [5:0] e_irq, e_irq_oe;
        logic [1:0] e_drq, e_drq_oe, e_addr;
        logic       e_dack, e_po, e_poe, dh;
        int nl;
        int j;
        nl = (m_mode == 2'b00) ? 6 : (m_mode == 2'b01) ? 8 : 0;
        for (int i = 0; i < 8; i++) begin
            logic h0, h1;
            h0 = m_s0[3] && (m_s0[2:0] == i[2:0]) && (i < nl);
            h1 = m_s1[3] && (m_s1[2:0] == i[2:0]) && (i < nl);
            hit[i] = h0 | h1;
            req[i] = (h0 & brd_irq[0]) | (h1 & brd_irq[1]);
        end
        e_irq = req[5:0]; e_irq_oe = hit[5:0];
        e_drq = '0; e_drq_oe = '0; e_dack = 1'b1; e_po = 1'b1; e_poe = 1'b0; e_addr = '0;
        if (m_mode == 2'b01) begin
            e_drq = req[7:6]; e_drq_oe = hit[7:6];
            e_dack = cs3_n; e_po = cs2_n; e_poe = 1'b1; e_addr = bus_dack_n;
        end else if (m_mode == 2'b00) begin
            dh = m_sd[3] && (m_sd[2:0] < 3'd2);
            j = int'(m_sd[0]);
            if (dh) begin
                e_drq_oe[j] = 1'b1;
                e_drq[j] = brd_drq;
                e_dack = bus_dack_n[j];
            end
        end
        if (m_mode[1]) begin
            check("R9 bus_irq", {20'd0, bus_irq_oe, bus_irq}, {20'd0, e_irq_oe, e_irq});
            check("R9 bus_drq", {27'd0, brd_dack_cs3_n, bus_drq_oe, bus_drq},
                  {27'd0, e_dack, e_drq_oe, e_drq});
        end else begin
            if (m_s0[3] && m_s1[3] && m_s0[2:0] == m_s1[2:0])
                check("R6 bus_irq", {20'd0, bus_irq_oe, bus_irq}, {20'd0, e_irq_oe, e_irq});
            else
                check("R4 bus_irq", {20'd0, bus_irq_oe, bus_irq}, {20'd0, e_irq_oe, e_irq});
            if (m_mode == 2'b01)
                check("R5 bus_drq", {28'd0, bus_drq_oe, bus_drq}, {28'd0, e_drq_oe, e_drq});
            else
                check("R7 bus_drq", {27'd0, brd_dack_cs3_n, bus_drq_oe, bus_drq},
                      {27'd0, e_dack, e_drq_oe, e_drq});
        end
        check("R8 pins", {26'd0, brd_dack_cs3_n, pin_drq_o, pin_drq_oe, 1'b0, ext_addr_hi},
              {26'd0, e_dack, e_po, e_poe, 1'b0, e_addr});
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_mode = 2'b00; m_s0 = '0; m_s1 = '0; m_sd = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, with requests active
        brd_irq = 2'b11; brd_drq = 1'b1; bus_dack_n = 2'b00;
        #1;
        check("R1 oe", {22'd0, bus_irq_oe, bus_drq_oe, brd_dack_cs3_n, pin_drq_oe},
              {22'd0, 6'd0, 2'd0, 1'b1, 1'b0});
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", {24'd0, bus_irq_oe, bus_drq_oe}, 32'd0);

        // R2: write lands only at the clock edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 4'b1011;
        #1;
        check("R2 before edge", {26'd0, bus_irq_oe}, 32'd0);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check("R2 after edge", {26'd0, bus_irq_oe}, 32'h8);
        // R3: enable cleared, index kept
        wr(2'd1, 4'b0011);
        check("R3 disabled", {26'd0, bus_irq_oe}, 32'd0);

        // R10: combinational path, no clock edge between change and sample
        wr(2'd1, 4'b1010);
        @(posedge clk); #0.5;
        brd_irq = 2'b00; #0.5;
        check("R10 low", {26'd0, bus_irq}, 32'd0);
        brd_irq = 2'b01; #0.5;
        check("R10 high", {26'd0, bus_irq}, 32'h4);

        // Sweep of modes and routing fields
        for (int md = 0; md < 4; md++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    m_mode = md[1:0]; m_s0 = a[3:0]; m_s1 = b[3:0];
                    m_sd = 4'((a + 3 * b) % 16);
                    wr(2'd0, {2'b00, m_mode});
                    wr(2'd1, m_s0);
                    wr(2'd2, m_s1);
                    wr(2'd3, m_sd);
                    for (int p = 0; p < 128; p++) begin
                        brd_irq    = p[1:0];
                        brd_drq    = p[2];
                        bus_dack_n = p[4:3];
                        cs2_n      = p[5];
                        cs3_n      = p[6];
                        #1;
                        compare_all();
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule